// File: doc/BRIEF.md
# Indirect RAM Access Port

This block lets a byte-wide register bus reach a 512-byte user RAM without giving that RAM a place in the register map. Software first loads a 9-bit location pointer through two pointer registers. It then moves data with two command registers. A write to the store command puts the data byte into the RAM at the pointer. A read of the fetch command returns the RAM byte at the pointer. After each command access the pointer moves to the next location. When it passes the last location it returns to zero, so a whole block of RAM can be streamed through one register address.

The register bus is simple. Each request lasts one cycle and is a write strobe or a read strobe with an address. A read answers one cycle later with a valid pulse and the data. That cycle covers the latency of the synchronous RAM. Reading the pointer registers shows where the pointer stands after any earlier increments. The serial front end that would drive this bus is not part of the block.

Top module: `iram_port`

## Requirements
- R1: After reset the pointer is 0, `rd_valid` is low and `rd_data` is 0x00.
- R2: A write to address 0x1B loads the pointer's low 8 bits from `wr_data`. A write to 0x1A loads pointer bit 8 from `wr_data[0]`. Bits 7..1 of that write are ignored.
- R3: A read of 0x1B returns pointer bits 7..0. A read of 0x1A returns pointer bit 8 in bit 0, with bits 7..1 as zero. Both return the pointer value as it stood in the request cycle.
- R4: A write to 0x1C stores `wr_data` in the RAM at the pointer, and the pointer then advances by one.
- R5: A read of 0x1D returns the RAM byte at the pointer, and the pointer then advances by one.
- R6: Every accepted read request is answered by `rd_valid` high for exactly the one following cycle, with `rd_data` valid in that cycle. `rd_valid` is low in every other cycle.
- R7: A command access made when the pointer is 511 leaves the pointer at 0.
- R8: The pointer does not change in a cycle without a request, nor after a read of 0x1A or 0x1B.
- R9: A write to any address other than 0x1A to 0x1D has no effect. A read of such an address is answered with 0x00.
- R10: If `wr_en` and `rd_en` are both high in one cycle, the write is performed and the read is dropped, so no `rd_valid` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request strobe |
| rd_en | input | 1 | Read request strobe |
| addr | input | 8 | Register address of the request |
| wr_data | input | 8 | Write data |
| rd_valid | output | 1 | Read answer valid, one cycle after the request |
| rd_data | output | 8 | Read answer data |

## Verification
The assertions assume that each request lasts a single cycle. The block does not require this, because it treats every high cycle as a new request, but the pointer and answer checks are written around it. The assertions also assume that the fetch command is never read at a location that has not been written since power-up.

The stimulus keeps within both assumptions:
- It drives every strobe for exactly one cycle, with an idle cycle between requests.
- It fills all 512 locations through the store command before it reads any of them back.

The only cycle with both strobes high is the deliberate one that exercises the dropped read.

// File: rtl/iram_port.sv
module iram_port #(
  parameter int AW = 9,
  parameter logic [7:0] A_HI = 8'h1A,
  parameter logic [7:0] A_LO = 8'h1B,
  parameter logic [7:0] A_WR = 8'h1C,
  parameter logic [7:0] A_RD = 8'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  localparam int HW    = AW - 8;
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_inc;

  wire rd_go  = rd_en & ~wr_en;
  wire do_st  = wr_en & (addr == A_WR);
  wire do_fe  = rd_go & (addr == A_RD);
  assign ptr_inc = ptr + {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr <= '0;
    else if (wr_en && addr == A_HI) ptr[AW-1:8] <= wr_data[HW-1:0];
    else if (wr_en && addr == A_LO) ptr[7:0] <= wr_data;
    else if (do_st || do_fe) ptr <= ptr_inc;

  always_ff @(posedge clk)
    if (do_st) mem[ptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_go;
      if (rd_go)
        case (addr)
          A_HI:    rd_data <= 8'(ptr[AW-1:8]);
          A_LO:    rd_data <= ptr[7:0];
          A_RD:    rd_data <= mem[ptr];
          default: rd_data <= 8'h00;
        endcase
    end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);
  assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> !rd_valid);
  assert_ptr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> $stable(ptr));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == AW'(DEPTH-1) && (do_st || do_fe)) |=> ptr == '0);
  assert_lo_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && addr == A_LO) |=> rd_data == $past(ptr[7:0]));
  assert_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && addr == A_HI) |=> rd_data[7:HW] == '0);
endmodule

// File: tb/sim_iram_port.sv
`timescale 1ns/1ps
module sim_iram_port;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00, wr_data = 8'h00;
  logic rd_valid;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  iram_port u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                .addr(addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) % 256) ^ ((i >= 256) ? 8'h5A : 8'h00);
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data; v = rd_valid;
  endtask

  task automatic get_ptr(output logic [8:0] p);
    logic [7:0] lo, hi; logic v1, v2;
    bread(8'h1B, lo, v1);
    bread(8'h1A, hi, v2);
    p = {hi[0], lo};
    if (!(v1 && v2) || hi[7:1] != 7'd0) check("R3 pointer read form", {v1, v2, hi[7:1]}, 9'h180);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v; logic [8:0] p;
    repeat (3) @(negedge clk);
    check("R1 rd_valid", {8'h0, rd_valid}, 9'h0);
    check("R1 rd_data", {1'b0, rd_data}, 9'h0);
    rst_n = 1'b1;
    get_ptr(p); check("R1 pointer", p, 9'h000);

    for (int i = 0; i < 512; i++) bwrite(8'h1C, pat(i));
    get_ptr(p); check("R7 R4 wrap after fill", p, 9'h000);

    for (int i = 0; i < 512; i++) begin
      bread(8'h1D, d, v);
      check("R5 fetch data", {1'b0, d}, {1'b0, pat(i)});
      check("R6 valid", {8'h0, v}, 9'h1);
    end
    get_ptr(p); check("R7 R5 wrap after fetch", p, 9'h000);
    @(negedge clk); check("R6 valid single cycle", {8'h0, rd_valid}, 9'h0);

    for (int k = 0; k < 16; k++) begin
      logic [8:0] t;
      t = 9'((k * 97 + 5) % 512);
      bwrite(8'h1A, {7'h7F, t[8]});
      bwrite(8'h1B, t[7:0]);
      get_ptr(p); check("R2 R3 pointer load", p, t);
      get_ptr(p); check("R8 pointer read no advance", p, t);
      bread(8'h1D, d, v);
      check("R5 random fetch", {1'b0, d}, {1'b0, pat(int'(t))});
      get_ptr(p); check("R5 advance", p, t + 9'd1);
    end

    bwrite(8'h1A, 8'h01); bwrite(8'h1B, 8'hFF);
    bwrite(8'h1C, 8'hC3);
    get_ptr(p); check("R7 store wrap", p, 9'h000);
    bwrite(8'h1A, 8'h01); bwrite(8'h1B, 8'hFF);
    bread(8'h1D, d, v); check("R4 store at 511", {1'b0, d}, 9'h0C3);

    bwrite(8'h1B, 8'h40); bwrite(8'h1A, 8'h00);
    repeat (5) @(negedge clk);
    get_ptr(p); check("R8 idle stable", p, 9'h040);
    bwrite(8'h33, 8'hAA); bwrite(8'h1E, 8'h55); bwrite(8'h19, 8'h01);
    get_ptr(p); check("R9 unmapped write", p, 9'h040);
    bread(8'h1D, d, v); check("R9 RAM untouched", {1'b0, d}, {1'b0, pat(64)});
    bread(8'h77, d, v); check("R9 unmapped read", {v, d}, 9'h100);

    bwrite(8'h1B, 8'h10);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 8'h1C; wr_data = 8'h9E;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R10 no valid", {8'h0, rd_valid}, 9'h0);
    get_ptr(p); check("R10 single advance", p, 9'h011);
    bwrite(8'h1B, 8'h10);
    bread(8'h1D, d, v); check("R10 write done", {1'b0, d}, 9'h09E);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule